// File: doc/BRIEF.md
# Per-Port Packet Trace Filter

This block watches the packet stream entering one switch input port and decides, once per packet, what the switch should do with it. The opening 160 bits of each packet are compared against a small bank of programmable entries. Each entry holds a value and a care mask. Any enabled entry that agrees with the packet on every cared bit counts as a hit.

On a hit, the port's action setting selects one of two outcomes. In trace mode, the packet is routed normally and a copy is also sent to a configured trace port. In filter mode, the packet is discarded. Packets with no hit are forwarded untouched. One instance sits on each input port and runs on its own.

Configuration arrives through a simple word write port that loads entry values, entry masks and a control word. The decision is a one-cycle pulse carrying an action code and, for trace, the trace port index. The switch fabric acts on it.

Top module: `tpf_trace_filter`

## Requirements
- R1: After reset no decision is pending, the matcher is off and every entry is disabled, so the first packet receives action code 2'b00 (forward).
- R2: Only the first WIN_BITS/W words of a packet (160 bits, 5 words at W=32) take part in the comparison; words after that window never change the decision.
- R3: An entry hits when, for every window word, each bit whose mask bit is 1 equals the entry value bit; mask bits of 0 are don't-care. Writes use cfg_kind 0 for value words and 1 for mask words, addressed by cfg_entry and cfg_word.
- R4: A hit on any single enabled entry is enough; an entry whose enable bit (control word bit 4+e for entry e) is 0 never causes a hit.
- R5: In trace mode (control bit 1 = 0) a hit gives code 2'b01 and dec_port equal to control bits [PW+15:16]; for any other code dec_port is 0.
- R6: In filter mode (control bit 1 = 1) a hit gives code 2'b10 (drop).
- R7: With no hit, or with the matcher off (control bit 0 = 0), the code is 2'b00; code 2'b11 never appears.
- R8: A packet shorter than the window is compared only over the words it carries; the missing words are don't-care.
- R9: Exactly one decision pulse is issued per packet, one cycle after the last window word or after the end-of-packet word if that comes first; no pulse follows a cycle without an accepted word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Packet word present this cycle |
| in_sop | input | 1 | First word of a packet |
| in_eop | input | 1 | Last word of a packet |
| in_data | input | W | Packet word, earliest bits first across words |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 2 | 0 value word, 1 mask word, 2 control word |
| cfg_entry | input | EIW | Entry index for value and mask writes |
| cfg_word | input | WIW | Window word index for value and mask writes |
| cfg_wdata | input | W | Write data |
| dec_valid | output | 1 | One-cycle decision pulse |
| dec_code | output | 2 | 00 forward, 01 forward plus trace copy, 10 drop |
| dec_port | output | PW | Trace port index, 0 unless code is 01 |

## Verification
Every accepted packet word is captured at a rising edge, and the decision for a packet is registered at the same edge that captures its deciding word. The pulse is therefore visible for the single cycle after that word was presented. The bench drives each word on a falling edge and samples dec_valid, dec_code and dec_port at the next falling edge. It expects the pulse exactly at the word with index min(length, 5) - 1 and expects it low on every other word and on the idle cycle after the packet. Configuration writes take effect one edge after they are presented and always finish before the next packet starts, so the bench's mirror of the settings matches the state the design decides with.

// File: rtl/tpf_pkg.sv
package tpf_pkg;

  typedef enum logic [1:0] {
    ACT_FWD   = 2'd0,
    ACT_TRACE = 2'd1,
    ACT_DROP  = 2'd2
  } act_e;

  localparam logic [1:0] CFG_VALUE = 2'd0;
  localparam logic [1:0] CFG_MASK  = 2'd1;
  localparam logic [1:0] CFG_CTRL  = 2'd2;

  // Bits that the mask cares about must agree; words up to 64 bits.
  function automatic logic masked_equal(logic [63:0] pkt, logic [63:0] val,
                                        logic [63:0] care);
    return ((pkt ^ val) & care) == 64'd0;
  endfunction

  function automatic act_e pick_action(logic any_hit, logic drop_mode);
    if (!any_hit)  return ACT_FWD;
    if (drop_mode) return ACT_DROP;
    return ACT_TRACE;
  endfunction

endpackage

// File: rtl/tpf_pos_track.sv
module tpf_pos_track #(
  parameter int WORDS = 5,
  localparam int PIW = $clog2(WORDS + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic           in_sop,
  input  logic           in_eop,
  output logic [PIW-1:0] eff_pos,
  output logic           in_window,
  output logic           trigger
);
  localparam logic [PIW-1:0] LIM  = PIW'(WORDS);
  localparam logic [PIW-1:0] LAST = PIW'(WORDS - 1);

  logic [PIW-1:0] pos_q;
  logic           done_q;
  logic           eff_done;

  // A start marker restarts the window regardless of leftover state.
  assign eff_pos   = in_sop ? '0 : pos_q;
  assign eff_done  = in_sop ? 1'b0 : done_q;
  assign in_window = eff_pos < LIM;
  assign trigger   = in_valid && in_window && !eff_done &&
                     ((eff_pos == LAST) || in_eop);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q  <= '0;
      done_q <= 1'b0;
    end else if (in_valid) begin
      pos_q  <= in_window ? eff_pos + 1'b1 : eff_pos;
      done_q <= eff_done | trigger;
    end
  end

  p_no_repeat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (trigger && !in_eop) |=> !(in_valid && !in_sop && trigger));

endmodule

// File: rtl/tpf_entry_bank.sv
module tpf_entry_bank
  import tpf_pkg::*;
#(
  parameter int N = 4,
  parameter int W = 32,
  parameter int WORDS = 5,
  localparam int PIW = $clog2(WORDS + 1),
  localparam int EIW = (N > 1) ? $clog2(N) : 1,
  localparam int WIW = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [1:0]     cfg_kind,
  input  logic [EIW-1:0] cfg_entry,
  input  logic [WIW-1:0] cfg_word,
  input  logic [W-1:0]   cfg_wdata,
  input  logic [W-1:0]   in_data,
  input  logic [PIW-1:0] eff_pos,
  input  logic           in_window,
  output logic [N-1:0]   word_hit
);
  logic word_ok;
  logic [PIW-1:0] sel;

  assign word_ok = int'(cfg_word) < WORDS;
  assign sel     = in_window ? eff_pos : '0;

  for (genvar e = 0; e < N; e++) begin : g_entry
    logic [W-1:0] val_q  [WORDS];
    logic [W-1:0] mask_q [WORDS];
    logic         sel_me;

    assign sel_me = cfg_we && word_ok && (int'(cfg_entry) == e);

    for (genvar k = 0; k < WORDS; k++) begin : g_word
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          val_q[k]  <= '0;
          mask_q[k] <= '0;
        end else if (sel_me && int'(cfg_word) == k) begin
          if (cfg_kind == CFG_VALUE) val_q[k]  <= cfg_wdata;
          if (cfg_kind == CFG_MASK)  mask_q[k] <= cfg_wdata;
        end
      end
    end

    assign word_hit[e] = masked_equal(64'(in_data), 64'(val_q[sel]),
                                      64'(mask_q[sel]));
  end

endmodule

// File: rtl/tpf_decide.sv
module tpf_decide
  import tpf_pkg::*;
#(
  parameter int N = 4,
  parameter int PW = 4,
  parameter int WORDS = 5,
  localparam int PIW = $clog2(WORDS + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic           in_window,
  input  logic [PIW-1:0] eff_pos,
  input  logic           trigger,
  input  logic [N-1:0]   word_hit,
  input  logic           ctrl_en,
  input  logic           ctrl_drop,
  input  logic [N-1:0]   ent_en,
  input  logic [PW-1:0]  tport,
  output logic           dec_valid,
  output logic [1:0]     dec_code,
  output logic [PW-1:0]  dec_port,
  output logic           any_hit
);
  logic [N-1:0] acc_q;
  logic [N-1:0] acc_next;
  act_e         act;

  // Running per-entry agreement over the window words seen so far.
  assign acc_next = ((eff_pos == '0) ? {N{1'b1}} : acc_q) & word_hit;
  assign any_hit  = ctrl_en && |(acc_next & ent_en);
  assign act      = pick_action(any_hit, ctrl_drop);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q     <= '0;
      dec_valid <= 1'b0;
      dec_code  <= ACT_FWD;
      dec_port  <= '0;
    end else begin
      if (in_valid && in_window) acc_q <= acc_next;
      dec_valid <= trigger;
      if (trigger) begin
        dec_code <= act;
        dec_port <= (act == ACT_TRACE) ? tport : '0;
      end
    end
  end

  p_code_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> dec_code != 2'b11);

  p_port_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_code != ACT_TRACE) |-> dec_port == '0);

  p_hit_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (trigger && !any_hit) |=> dec_code == ACT_FWD);

endmodule

// File: rtl/tpf_trace_filter.sv
module tpf_trace_filter
  import tpf_pkg::*;
#(
  parameter int WIN_BITS = 160,
  parameter int W = 32,
  parameter int N = 4,
  parameter int PW = 4,
  localparam int WORDS = WIN_BITS / W,
  localparam int PIW = $clog2(WORDS + 1),
  localparam int EIW = (N > 1) ? $clog2(N) : 1,
  localparam int WIW = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic           in_sop,
  input  logic           in_eop,
  input  logic [W-1:0]   in_data,
  input  logic           cfg_we,
  input  logic [1:0]     cfg_kind,
  input  logic [EIW-1:0] cfg_entry,
  input  logic [WIW-1:0] cfg_word,
  input  logic [W-1:0]   cfg_wdata,
  output logic           dec_valid,
  output logic [1:0]     dec_code,
  output logic [PW-1:0]  dec_port
);
  logic           ctrl_en_q;
  logic           ctrl_drop_q;
  logic [N-1:0]   ent_en_q;
  logic [PW-1:0]  tport_q;
  logic [PIW-1:0] eff_pos;
  logic           in_window;
  logic           trigger;
  logic [N-1:0]   word_hit;
  logic           any_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_en_q   <= 1'b0;
      ctrl_drop_q <= 1'b0;
      ent_en_q    <= '0;
      tport_q     <= '0;
    end else if (cfg_we && cfg_kind == CFG_CTRL) begin
      ctrl_en_q   <= cfg_wdata[0];
      ctrl_drop_q <= cfg_wdata[1];
      ent_en_q    <= cfg_wdata[N+3:4];
      tport_q     <= cfg_wdata[PW+15:16];
    end
  end

  tpf_pos_track #(.WORDS(WORDS)) u_pos (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
    .in_eop(in_eop), .eff_pos(eff_pos), .in_window(in_window),
    .trigger(trigger)
  );

  tpf_entry_bank #(.N(N), .W(W), .WORDS(WORDS)) u_bank (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
    .cfg_entry(cfg_entry), .cfg_word(cfg_word), .cfg_wdata(cfg_wdata),
    .in_data(in_data), .eff_pos(eff_pos), .in_window(in_window),
    .word_hit(word_hit)
  );

  tpf_decide #(.N(N), .PW(PW), .WORDS(WORDS)) u_dec (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_window(in_window),
    .eff_pos(eff_pos), .trigger(trigger), .word_hit(word_hit),
    .ctrl_en(ctrl_en_q), .ctrl_drop(ctrl_drop_q), .ent_en(ent_en_q),
    .tport(tport_q), .dec_valid(dec_valid), .dec_code(dec_code),
    .dec_port(dec_port), .any_hit(any_hit)
  );

  p_dec_after_word_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> $past(in_valid));

  p_late_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_sop && !in_window) |=> !dec_valid);

  p_off_fwd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !$past(ctrl_en_q)) |-> dec_code == ACT_FWD);

  p_no_entry_fwd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && $past(ent_en_q) == '0) |-> dec_code == ACT_FWD);

endmodule

// File: tb/sim_tpf_trace_filter.sv
`timescale 1ns/1ps
module sim_tpf_trace_filter;
  localparam int NW = 5;
  localparam int NE = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
  logic [31:0] in_data = '0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_kind = '0;
  logic [1:0]  cfg_entry = '0;
  logic [2:0]  cfg_word = '0;
  logic [31:0] cfg_wdata = '0;
  logic        dec_valid;
  logic [1:0]  dec_code;
  logic [3:0]  dec_port;

  int tests = 0, fails = 0;
  bit finished = 0;

  logic [31:0] mv [NE][NW];
  logic [31:0] mm [NE][NW];
  logic        men, mdrop;
  logic [3:0]  ment, mtp;
  logic [31:0] pk [16];

  always #4 clk = ~clk;

  tpf_trace_filter u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
    .in_eop(in_eop), .in_data(in_data), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
    .cfg_entry(cfg_entry), .cfg_word(cfg_word), .cfg_wdata(cfg_wdata),
    .dec_valid(dec_valid), .dec_code(dec_code), .dec_port(dec_port)
  );

  function automatic logic [1:0] exp_code(int len);
    int lim = (len < NW) ? len : NW;
    logic hit = 1'b0;
    for (int e = 0; e < NE; e++) begin
      logic ok = ment[e];
      for (int i = 0; i < lim; i++)
        if (((pk[i] ^ mv[e][i]) & mm[e][i]) != 0) ok = 1'b0;
      hit |= ok;
    end
    if (!men || !hit) return 2'b00;
    return mdrop ? 2'b10 : 2'b01;
  endfunction

  task automatic cfg_wr(logic [1:0] k, int e, int w, logic [31:0] d);
    cfg_we = 1'b1; cfg_kind = k; cfg_entry = 2'(e); cfg_word = 3'(w);
    cfg_wdata = d;
    if (k == 2'd0) mv[e][w] = d;
    if (k == 2'd1) mm[e][w] = d;
    if (k == 2'd2) begin
      men = d[0]; mdrop = d[1]; ment = d[7:4]; mtp = d[19:16];
    end
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic ctrl(logic en, logic drop, logic [3:0] ens, logic [3:0] tp);
    cfg_wr(2'd2, 0, 0, {12'd0, tp, 8'd0, ens, 2'b00, drop, en});
  endtask

  task automatic chk(logic expv, logic [1:0] ec, string tag);
    tests++;
    if (dec_valid !== expv) begin
      fails++;
      $display("FAIL %s dec_valid actual=%0b expected=%0b", tag, dec_valid, expv);
    end
    if (expv) begin
      logic [3:0] ep = (ec == 2'b01) ? mtp : 4'd0;
      tests++;
      if (dec_code !== ec) begin
        fails++;
        $display("FAIL %s dec_code actual=%0d expected=%0d", tag, dec_code, ec);
      end
      tests++;
      if (dec_port !== ep) begin
        fails++;
        $display("FAIL %s dec_port actual=%0d expected=%0d", tag, dec_port, ep);
      end
    end
  endtask

  task automatic send_pkt(int len, string tag);
    logic [1:0] ec = exp_code(len);
    int lim = (len < NW) ? len : NW;
    for (int i = 0; i < len; i++) begin
      in_valid = 1'b1; in_sop = (i == 0); in_eop = (i == len - 1);
      in_data = pk[i];
      @(negedge clk);
      chk(i == lim - 1, ec, tag);
    end
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
    @(negedge clk);
    chk(1'b0, 2'b00, tag);
  endtask

  task automatic load_entry(int e, logic [31:0] base, logic [31:0] care);
    for (int w = 0; w < NW; w++) begin
      cfg_wr(2'd0, e, w, base + 32'(w));
      cfg_wr(2'd1, e, w, care);
    end
  endtask

  task automatic fill_pkt(logic [31:0] base);
    for (int i = 0; i < 16; i++) pk[i] = (i < NW) ? base + 32'(i) : $urandom;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1f2e3d4c));
    for (int e = 0; e < NE; e++)
      for (int w = 0; w < NW; w++) begin mv[e][w] = 0; mm[e][w] = 0; end
    men = 0; mdrop = 0; ment = 0; mtp = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(1'b0, 2'b00, "R1 idle after reset");
    fill_pkt(32'h1000);
    send_pkt(3, "R1 reset forward");

    // Entry 0 exact match, trace to port 9
    load_entry(0, 32'hA000, 32'hFFFF_FFFF);
    ctrl(1'b1, 1'b0, 4'b0001, 4'd9);
    fill_pkt(32'hA000);
    send_pkt(7, "R5 trace hit");
    pk[6] = ~pk[6]; pk[5] = 32'h0;
    send_pkt(9, "R2 tail ignored");
    pk[4] = pk[4] ^ 32'h100;
    send_pkt(6, "R3 cared bit differs");
    // don't-care bit
    cfg_wr(2'd1, 0, 2, 32'hFFFF_FFFE);
    fill_pkt(32'hA000); pk[2] ^= 32'h1;
    send_pkt(5, "R3 masked bit ignored");
    // short packet
    fill_pkt(32'hA000); pk[3] = 32'h0;
    send_pkt(2, "R8 short packet hit");
    send_pkt(1, "R8 single word");
    send_pkt(4, "R8 window word differs");
    // any entry, disabled entries
    load_entry(3, 32'h0, 32'h0);
    ctrl(1'b1, 1'b0, 4'b1000, 4'd3);
    fill_pkt(32'h5555);
    send_pkt(6, "R4 catch-all entry");
    ctrl(1'b1, 1'b0, 4'b0000, 4'd3);
    send_pkt(6, "R4 disabled entries");
    // filter mode
    ctrl(1'b1, 1'b1, 4'b0001, 4'd7);
    fill_pkt(32'hA000);
    send_pkt(5, "R6 drop hit");
    ctrl(1'b0, 1'b1, 4'b1111, 4'd7);
    send_pkt(5, "R7 matcher off");

    // random
    for (int r = 0; r < 400; r++) begin
      if (r % 25 == 0) begin
        for (int e = 0; e < NE; e++)
          for (int w = 0; w < NW; w++) begin
            int s = $urandom_range(0, 2);
            cfg_wr(2'd0, e, w, $urandom);
            cfg_wr(2'd1, e, w, (s == 0) ? 32'hFFFF_FFFF :
                               (s == 1) ? 32'($urandom) : 32'h0);
          end
        ctrl($urandom_range(0, 7) != 0, 1'($urandom), 4'($urandom),
             4'($urandom));
      end
      begin
        int len = $urandom_range(1, 12);
        int e = $urandom_range(0, NE - 1);
        bit near = $urandom_range(0, 3) != 0;
        for (int i = 0; i < 16; i++) begin
          pk[i] = $urandom;
          if (near && i < NW) pk[i] = (mv[e][i] & mm[e][i]) | (pk[i] & ~mm[e][i]);
        end
        if ($urandom_range(0, 4) == 0) pk[$urandom_range(0, NW - 1)] ^= 32'h8000;
        send_pkt(len, "R9 random packet");
      end
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule